// File: doc/BRIEF.md
# Two-Stage Countdown Watchdog

This block is a watchdog timer with a small register interface. A 10-bit counter counts down by one on each qualified tick pulse. Software programs an initial count, restarts the timer by writing the reload register, halts or releases it through a control bit, and reads back the remaining count. Every read and write uses full 16-bit strobes, and the read data comes out of a register.

Expiry happens in two stages. At the first expiry the block reloads the counter, sets a first-timeout flag and pulses an interrupt request. If the counter expires again while that flag is still set, the block sets a second-timeout flag, sets a boot flag and pulses a system reset request. A no-reboot input can suppress that request. Software must therefore service the timer and clear the first-timeout flag before the second expiry. Doing so restarts the two-stage sequence.

Top module: `dual_expiry_wdt`

## Requirements
- R1: After synchronous reset the halt bit (control register at byte offset 0x08, bit 11) reads 1. The initial count (offset 0x12) reads 4 and the remaining count (offset 0x00) reads 4. Every status bit reads 0, and irq_o and sys_rst_req_o are low.
- R2: A write to offset 0x12 with a count field (bits [9:0]) of 4 or more stores that count. Bits [15:10] are a scratch field that every write to offset 0x12 updates, and both parts read back as written.
- R3: A write to offset 0x12 whose count field is 0, 1, 2 or 3 leaves the stored count unchanged.
- R4: Any write to offset 0x00 loads the counter with the stored initial count. A read of offset 0x00 returns the remaining count in bits [9:0] and zeros above.
- R5: While the halt bit is 1, tick pulses leave the count unchanged and produce no expiry. Writing 0 to bit 11 of offset 0x08 lets the counter run, and the bit reads back the value written.
- R6: Each tick with the timer running lowers the count by one. The tick that finds a count of 1 is the expiry: it loads the initial count on that same tick, so an initial count of N gives an expiry on every Nth tick.
- R7: An expiry while the first-timeout flag (offset 0x04, bit 3) is clear sets that flag and raises irq_o for exactly one cycle, with no reset request.
- R8: An expiry while the first-timeout flag is set does three things: it sets the second-timeout flag (offset 0x06, bit 1), sets the boot flag (offset 0x06, bit 2) and raises sys_rst_req_o for exactly one cycle. The first-timeout flag stays set and irq_o stays low.
- R9: Writing 1 to bit 3 of offset 0x04 clears the first-timeout flag, so the next expiry acts as a first expiry again.
- R10: When no_reboot_i is high at a second-stage expiry, sys_rst_req_o stays low and the boot flag is not set, but the second-timeout flag is still set.
- R11: Status bits clear only when 1 is written to their own position. Writing 0 leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle tick enable that paces the countdown |
| no_reboot_i | input | 1 | Suppresses the reset request when high |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 5 | Register byte offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data, valid the cycle after rd_en_i, held otherwise |
| irq_o | output | 1 | One-cycle pulse on a first-stage expiry |
| sys_rst_req_o | output | 1 | One-cycle pulse on a second-stage expiry |

## Verification
The hardest state to reach is a second-stage expiry that arrives after software has serviced only part of the sequence. The bench has to pin down that clearing the boot and second-timeout bits does not re-arm the first stage, and that only clearing bit 3 does. The stimulus leaves the first flag set through a full interval so that the reset request fires, then clears each status bit separately, including writes of 0. Only after that does it run another interval, and it expects an interrupt rather than a reset. The no-reboot case reaches the same second-stage expiry with the input raised. It then checks both that the output stays silent and that the second-timeout flag is still set.

// File: rtl/dxw_pkg.sv
package dxw_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_RELOAD = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT1  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_STAT2  = 5'h06;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_INIT   = 5'h12;

  localparam int unsigned BIT_FIRST  = 3;
  localparam int unsigned BIT_SECOND = 1;
  localparam int unsigned BIT_BOOT   = 2;
  localparam int unsigned BIT_HALT   = 11;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RELOAD,
    SEL_STAT1,
    SEL_STAT2,
    SEL_CTRL,
    SEL_INIT
  } reg_sel_e;
endpackage

// File: rtl/dxw_decode.sv
module dxw_decode
  import dxw_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  always_comb begin
    case (addr_i)
      OFS_RELOAD: sel_o = SEL_RELOAD;
      OFS_STAT1:  sel_o = SEL_STAT1;
      OFS_STAT2:  sel_o = SEL_STAT2;
      OFS_CTRL:   sel_o = SEL_CTRL;
      OFS_INIT:   sel_o = SEL_INIT;
      default:    sel_o = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/dxw_counter.sv
module dxw_counter #(
  parameter int unsigned CNT_W        = 10,
  parameter int unsigned EXTRA_W      = 6,
  parameter int unsigned INIT_DEFAULT = 4,
  parameter int unsigned MIN_INIT     = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_i,
  input  logic               halt_i,
  input  logic               reload_wr_i,
  input  logic               init_wr_i,
  input  logic [CNT_W-1:0]   init_cnt_i,
  input  logic [EXTRA_W-1:0] init_extra_i,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [CNT_W-1:0]   init_o,
  output logic [EXTRA_W-1:0] extra_o,
  output logic               expire_o
);
  localparam logic [CNT_W-1:0] INIT_RST = CNT_W'(INIT_DEFAULT);
  localparam logic [CNT_W-1:0] INIT_MIN = CNT_W'(MIN_INIT);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   init_q;
  logic [EXTRA_W-1:0] extra_q;
  logic               run;

  assign run      = tick_i && !halt_i && !reload_wr_i;
  assign expire_o = run && (cnt_q <= ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      init_q  <= INIT_RST;
      extra_q <= '0;
    end else if (init_wr_i) begin
      extra_q <= init_extra_i;
      if (init_cnt_i >= INIT_MIN) init_q <= init_cnt_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= INIT_RST;
    else if (reload_wr_i)   cnt_q <= init_q;
    else if (expire_o)      cnt_q <= init_q;
    else if (run)           cnt_q <= cnt_q - ONE;
  end

  assign cnt_o   = cnt_q;
  assign init_o  = init_q;
  assign extra_o = extra_q;

  assert_init_legal_R3: assert property (@(posedge clk) disable iff (rst)
    init_q >= INIT_MIN);
  assert_halt_freeze_R5: assert property (@(posedge clk) disable iff (rst)
    (halt_i && !reload_wr_i) |=> $stable(cnt_q));
  assert_cnt_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
    cnt_q != '0);
  assert_expire_reload_R6: assert property (@(posedge clk) disable iff (rst)
    expire_o |=> (cnt_q == $past(init_q)));
endmodule

// File: rtl/dxw_stage.sv
module dxw_stage (
  input  logic clk,
  input  logic rst,
  input  logic expire_i,
  input  logic no_reboot_i,
  input  logic clr_first_i,
  input  logic clr_second_i,
  input  logic clr_boot_i,
  output logic first_o,
  output logic second_o,
  output logic boot_o,
  output logic irq_o,
  output logic rst_req_o
);
  logic first_q, second_q, boot_q, irq_q, rst_req_q;
  logic stage1_hit, stage2_hit;

  assign stage1_hit = expire_i && !first_q;
  assign stage2_hit = expire_i &&  first_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q   <= 1'b0;
      second_q  <= 1'b0;
      boot_q    <= 1'b0;
      irq_q     <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      irq_q     <= stage1_hit;
      rst_req_q <= stage2_hit && !no_reboot_i;
      if (stage1_hit)       first_q <= 1'b1;
      else if (clr_first_i) first_q <= 1'b0;
      if (stage2_hit)        second_q <= 1'b1;
      else if (clr_second_i) second_q <= 1'b0;
      if (stage2_hit && !no_reboot_i) boot_q <= 1'b1;
      else if (clr_boot_i)            boot_q <= 1'b0;
    end
  end

  assign first_o   = first_q;
  assign second_o  = second_q;
  assign boot_o    = boot_q;
  assign irq_o     = irq_q;
  assign rst_req_o = rst_req_q;

  assert_irq_single_R7: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q);
  assert_irq_sets_first_R7: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> first_q);
  assert_rst_after_first_R8: assert property (@(posedge clk) disable iff (rst)
    rst_req_q |-> (second_q && boot_q && $past(first_q)));
  assert_pulses_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !(irq_q && rst_req_q));
  assert_noreboot_blocks_R10: assert property (@(posedge clk) disable iff (rst)
    rst_req_q |-> !$past(no_reboot_i));
endmodule

// File: rtl/dual_expiry_wdt.sv
module dual_expiry_wdt
  import dxw_pkg::*;
#(
  parameter int unsigned CNT_W        = 10,
  parameter int unsigned INIT_DEFAULT = 4,
  parameter int unsigned MIN_INIT     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              no_reboot_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              sys_rst_req_o
);
  localparam int unsigned EXTRA_W = DATA_W - CNT_W;

  reg_sel_e            sel;
  logic                halt_q;
  logic [CNT_W-1:0]    cnt, init_cnt;
  logic [EXTRA_W-1:0]  init_extra;
  logic                expire;
  logic                first_f, second_f, boot_f;
  logic [DATA_W-1:0]   rd_mux, rdata_q;
  logic                wr_reload, wr_init, wr_stat1, wr_stat2, wr_ctrl;

  dxw_decode u_decode (.addr_i(addr_i), .sel_o(sel));

  assign wr_reload = wr_en_i && (sel == SEL_RELOAD);
  assign wr_init   = wr_en_i && (sel == SEL_INIT);
  assign wr_stat1  = wr_en_i && (sel == SEL_STAT1);
  assign wr_stat2  = wr_en_i && (sel == SEL_STAT2);
  assign wr_ctrl   = wr_en_i && (sel == SEL_CTRL);

  always_ff @(posedge clk) begin
    if (rst)          halt_q <= 1'b1;
    else if (wr_ctrl) halt_q <= wdata_i[BIT_HALT];
  end

  dxw_counter #(
    .CNT_W(CNT_W), .EXTRA_W(EXTRA_W),
    .INIT_DEFAULT(INIT_DEFAULT), .MIN_INIT(MIN_INIT)
  ) u_counter (
    .clk(clk), .rst(rst), .tick_i(tick_i), .halt_i(halt_q),
    .reload_wr_i(wr_reload), .init_wr_i(wr_init),
    .init_cnt_i(wdata_i[CNT_W-1:0]), .init_extra_i(wdata_i[DATA_W-1:CNT_W]),
    .cnt_o(cnt), .init_o(init_cnt), .extra_o(init_extra), .expire_o(expire)
  );

  dxw_stage u_stage (
    .clk(clk), .rst(rst), .expire_i(expire), .no_reboot_i(no_reboot_i),
    .clr_first_i(wr_stat1 && wdata_i[BIT_FIRST]),
    .clr_second_i(wr_stat2 && wdata_i[BIT_SECOND]),
    .clr_boot_i(wr_stat2 && wdata_i[BIT_BOOT]),
    .first_o(first_f), .second_o(second_f), .boot_o(boot_f),
    .irq_o(irq_o), .rst_req_o(sys_rst_req_o)
  );

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_RELOAD: rd_mux[CNT_W-1:0] = cnt;
      SEL_INIT:   rd_mux = {init_extra, init_cnt};
      SEL_STAT1:  rd_mux[BIT_FIRST] = first_f;
      SEL_STAT2: begin
        rd_mux[BIT_SECOND] = second_f;
        rd_mux[BIT_BOOT]   = boot_f;
      end
      SEL_CTRL:   rd_mux[BIT_HALT] = halt_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end
  assign rdata_o = rdata_q;

  assert_halt_no_expiry_R5: assert property (@(posedge clk) disable iff (rst)
    halt_q |=> !(irq_o || sys_rst_req_o));
  assert_halt_readback_R5: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl |=> (halt_q == $past(wdata_i[BIT_HALT])));
endmodule

// File: tb/dual_expiry_wdt_bench.sv
module dual_expiry_wdt_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_i = 1'b0;
  logic        no_reboot_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        irq_o, sys_rst_req_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_expiry_wdt u_dual_expiry_wdt (
    .clk(clk), .rst(rst), .tick_i(tick_i), .no_reboot_i(no_reboot_i),
    .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o), .sys_rst_req_o(sys_rst_req_o)
  );

  localparam logic [4:0] A_RLD = 5'h00, A_S1 = 5'h04, A_S2 = 5'h06,
                         A_CTL = 5'h08, A_INI = 5'h12;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    addr_i = a; rd_en_i = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_en_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic rd_check(input string req, input logic [4:0] a, input logic [15:0] exp);
    logic [15:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  // one tick; returns the pulse outputs seen right after it
  task automatic tick(output logic irq_s, output logic rst_s);
    tick_i = 1'b1;
    @(posedge clk); @(negedge clk);
    tick_i = 1'b0;
    irq_s = irq_o; rst_s = sys_rst_req_o;
  endtask

  task automatic ticks(input int n, output int irq_n, output int rst_n);
    logic a, b;
    irq_n = 0; rst_n = 0;
    for (int i = 0; i < n; i++) begin
      tick(a, b);
      irq_n += int'(a); rst_n += int'(b);
    end
  endtask

  task automatic t_reset;
    check("R1 irq low", {15'b0, irq_o}, 16'h0);
    check("R1 rst_req low", {15'b0, sys_rst_req_o}, 16'h0);
    rd_check("R1 halt set", A_CTL, 16'h0800);
    rd_check("R1 init default", A_INI, 16'h0004);
    rd_check("R1 count default", A_RLD, 16'h0004);
    rd_check("R1 status1 clear", A_S1, 16'h0000);
    rd_check("R1 status2 clear", A_S2, 16'h0000);
  endtask

  task automatic t_init;
    wr(A_INI, 16'hFC0A);
    rd_check("R2 init with scratch", A_INI, 16'hFC0A);
    wr(A_INI, 16'h03FF);
    rd_check("R2 init max", A_INI, 16'h03FF);
  endtask

  task automatic t_invalid;
    for (int v = 0; v < 4; v++) begin
      wr(A_INI, 16'(v));
      rd_check("R3 small value ignored", A_INI, 16'h03FF);
    end
  endtask

  task automatic t_reload;
    wr(A_RLD, 16'h0000);
    rd_check("R4 reload to max", A_RLD, 16'h03FF);
    wr(A_INI, 16'h0006);
    rd_check("R4 init write leaves count", A_RLD, 16'h03FF);
    wr(A_RLD, 16'hABCD);
    rd_check("R4 reload to 6", A_RLD, 16'h0006);
  endtask

  task automatic t_halt;
    int ni, nr;
    ticks(5, ni, nr);
    rd_check("R5 halted count frozen", A_RLD, 16'h0006);
    check("R5 no pulse while halted", 16'(ni + nr), 16'h0);
    wr(A_CTL, 16'h0000);
    rd_check("R5 halt readback 0", A_CTL, 16'h0000);
  endtask

  task automatic t_first;
    int ni, nr;
    logic a, b;
    ticks(5, ni, nr);
    rd_check("R6 count after 5 ticks", A_RLD, 16'h0001);
    check("R6 no early pulse", 16'(ni + nr), 16'h0);
    tick(a, b);
    check("R7 irq on first expiry", {15'b0, a}, 16'h1);
    check("R7 no rst on first expiry", {15'b0, b}, 16'h0);
    @(posedge clk); @(negedge clk);
    check("R7 irq one cycle", {15'b0, irq_o}, 16'h0);
    rd_check("R6 reloaded same tick", A_RLD, 16'h0006);
    rd_check("R7 first flag", A_S1, 16'h0008);
  endtask

  task automatic t_second;
    int ni, nr;
    logic a, b;
    ticks(5, ni, nr);
    tick(a, b);
    check("R8 rst_req on second expiry", {15'b0, b}, 16'h1);
    check("R8 no irq on second expiry", {15'b0, a}, 16'h0);
    @(posedge clk); @(negedge clk);
    check("R8 rst_req one cycle", {15'b0, sys_rst_req_o}, 16'h0);
    rd_check("R8 second and boot flags", A_S2, 16'h0006);
    rd_check("R8 first flag stays", A_S1, 16'h0008);
  endtask

  task automatic t_clear;
    int ni, nr;
    wr(A_S2, 16'h0000);
    rd_check("R11 zero write no effect", A_S2, 16'h0006);
    wr(A_S2, 16'h0002);
    rd_check("R11 clear second only", A_S2, 16'h0004);
    wr(A_S2, 16'h0004);
    rd_check("R11 clear boot", A_S2, 16'h0000);
    wr(A_S1, 16'hFFF7);
    rd_check("R11 other bits no clear", A_S1, 16'h0008);
    wr(A_S1, 16'h0008);
    rd_check("R9 first cleared", A_S1, 16'h0000);
    wr(A_RLD, 16'h0001);
    ticks(6, ni, nr);
    check("R9 restarted: irq", 16'(ni), 16'h1);
    check("R9 restarted: no rst", 16'(nr), 16'h0);
  endtask

  task automatic t_noreboot;
    int ni, nr;
    no_reboot_i = 1'b1;
    ticks(6, ni, nr);
    check("R10 reset suppressed", 16'(nr), 16'h0);
    check("R10 no irq", 16'(ni), 16'h0);
    rd_check("R10 second set, boot not", A_S2, 16'h0002);
    no_reboot_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_init();
    t_invalid();
    t_reload();
    t_halt();
    t_first();
    t_second();
    t_clear();
    t_noreboot();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule